// File: doc/BRIEF.md
# Conditional Relative Jump Unit

This block resolves a single PC-relative conditional jump. Each cycle that `in_valid` is high, it takes the address of the jump instruction, a 3-bit condition selector, a 10-bit signed word offset and the four status flags (carry, zero, negative, overflow). It decides whether the jump is taken and produces the address of the next instruction to fetch. That address is the branch target when the jump is taken and the next sequential instruction when it is not.

The target is measured from the address that follows the jump instruction, not from the jump itself. The offset counts 16-bit words, so it is sign-extended and doubled before it is added. This gives a reach of −1024 to +1022 bytes around the following instruction. The condition set is not symmetric. One code jumps on a negative result, and no code jumps on a non-negative one.

The result is registered. `out_valid`, `taken` and `next_pc` appear one clock after the request. They hold their values until the next request.

Top module: `jcu_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `taken` and `next_pc` are all 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Results appear with one cycle of latency.
- R3: Condition code 3'b000 is taken when Z is 0. Code 3'b001 is taken when Z is 1. Neither depends on C, N or V.
- R4: Condition code 3'b010 is taken when C is 0. Code 3'b011 is taken when C is 1.
- R5: Condition code 3'b100 is taken only when N is 1. With N at 0 it is never taken, whatever the other flags are.
- R6: Code 3'b101 is taken when N equals V. Code 3'b110 is taken when N differs from V. Code 3'b111 is always taken.
- R7: When taken, `next_pc` = (aligned address + 2) + 2 × sign-extended `offset`, modulo 2^16. For example, address 0xC028 with offset 10'b1111110011 gives 0xC010.
- R8: When not taken, `next_pc` = aligned address + 2, modulo 2^16. For example, 0xFFFE gives 0x0000.
- R9: Bit 0 of `instr_addr` is ignored. The aligned address has bit 0 cleared, and `next_pc` bit 0 is always 0.
- R10: In a cycle after one where `in_valid` is low, `taken` and `next_pc` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| instr_addr | input | 16 | Address of the jump instruction |
| cond | input | 3 | Condition selector |
| offset | input | 10 | Signed word offset |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| taken | output | 1 | Jump decision |
| next_pc | output | 16 | Next instruction address |

## Verification
The hardest cases to reach are the wrap-around targets. A jump near the top of the address space with a positive offset must wrap to low memory. A jump near address zero with a negative offset must wrap to the top. Random addresses almost never land near these ends, so directed requests are placed there: at 0xFFFE and 0xFFF0 with forward offsets, and at 0x0002 with the most negative offset. Random requests with odd addresses and all 128 pairings of condition code and flag values are mixed in, so that every condition is seen both taken and not taken.

// File: rtl/jcu_pkg.sv
package jcu_pkg;

    typedef enum logic [2:0] {
        CC_ZERO_CLR = 3'b000,
        CC_ZERO_SET = 3'b001,
        CC_CARRY_CLR = 3'b010,
        CC_CARRY_SET = 3'b011,
        CC_NEG_SET  = 3'b100,
        CC_SGN_GE   = 3'b101,
        CC_SGN_LT   = 3'b110,
        CC_ALWAYS   = 3'b111
    } jcond_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } jflags_t;

    function automatic logic cond_met(jcond_e cc, jflags_t f);
        logic r;
        unique case (cc)
            CC_ZERO_CLR:  r = ~f.z;
            CC_ZERO_SET:  r = f.z;
            CC_CARRY_CLR: r = ~f.c;
            CC_CARRY_SET: r = f.c;
            CC_NEG_SET:   r = f.n;
            CC_SGN_GE:    r = ~(f.n ^ f.v);
            CC_SGN_LT:    r = f.n ^ f.v;
            default:      r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/jcu_cond_eval.sv
module jcu_cond_eval
    import jcu_pkg::*;
(
    input  jcond_e  cc_i,
    input  jflags_t flags_i,
    output logic    take_o
);
    always_comb begin
        take_o = cond_met(cc_i, flags_i);
    end
endmodule

// File: rtl/jcu_target_gen.sv
module jcu_target_gen #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 10
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [ADDR_W-1:0] seq_o,
    output logic [ADDR_W-1:0] tgt_o
);
    localparam int EXT_W = ADDR_W - OFF_W - 1;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] disp;

    always_comb begin
        base  = pc_i & ALIGN_MASK;
        disp  = {{EXT_W{off_i[OFF_W-1]}}, off_i, 1'b0};
        seq_o = base + STEP;
        tgt_o = seq_o + disp;
    end
endmodule

// File: rtl/jcu_top.sv
module jcu_top
    import jcu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] instr_addr,
    input  logic [2:0]        cond,
    input  logic [OFF_W-1:0]  offset,
    input  logic              flag_c,
    input  logic              flag_z,
    input  logic              flag_n,
    input  logic              flag_v,
    output logic              out_valid,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc
);
    jflags_t           flags;
    logic              take_d;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] tgt_pc;

    always_comb begin
        flags = '{c: flag_c, z: flag_z, n: flag_n, v: flag_v};
    end

    jcu_cond_eval u_cond (
        .cc_i    (jcond_e'(cond)),
        .flags_i (flags),
        .take_o  (take_d)
    );

    jcu_target_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
        .pc_i  (instr_addr),
        .off_i (offset),
        .seq_o (seq_pc),
        .tgt_o (tgt_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            next_pc   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                taken   <= take_d;
                next_pc <= take_d ? tgt_pc : seq_pc;
            end
        end
    end
endmodule

// File: rtl/jcu_checker.sv
module jcu_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [ADDR_W-1:0] instr_addr,
    input logic [2:0]        cond,
    input logic              flag_n,
    input logic              out_valid,
    input logic              taken,
    input logic [ADDR_W-1:0] next_pc
);
    p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_fall_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_neg_only_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 3'b100 && !flag_n) |=> !taken);
    p_always_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 3'b111) |=> taken);
    p_seq_addr_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (taken || next_pc ==
            ({$past(instr_addr[ADDR_W-1:1]), 1'b0} + ADDR_W'(2))));
    p_even_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !next_pc[0]);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(next_pc) && $stable(taken)));
endmodule

bind jcu_top jcu_checker #(.ADDR_W(ADDR_W)) u_jcu_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .instr_addr (instr_addr),
    .cond       (cond),
    .flag_n     (flag_n),
    .out_valid  (out_valid),
    .taken      (taken),
    .next_pc    (next_pc)
);

// File: tb/test_jcu_top.sv
module test_jcu_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] instr_addr;
    logic [2:0]  cond;
    logic [9:0]  offset;
    logic        flag_c, flag_z, flag_n, flag_v;
    logic        out_valid, taken;
    logic [15:0] next_pc;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    jcu_top i_jcu_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr_addr(instr_addr),
        .cond(cond), .offset(offset), .flag_c(flag_c), .flag_z(flag_z),
        .flag_n(flag_n), .flag_v(flag_v), .out_valid(out_valid),
        .taken(taken), .next_pc(next_pc)
    );

    function automatic bit want_take(logic [2:0] cc, bit c, bit z, bit n, bit v);
        case (cc)
            3'd0: return !z;
            3'd1: return z;
            3'd2: return !c;
            3'd3: return c;
            3'd4: return n;
            3'd5: return n == v;
            3'd6: return n != v;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [15:0] want_pc(logic [15:0] a, logic [9:0] off, bit tk);
        logic [15:0] seq;
        logic [15:0] sx;
        seq = {a[15:1], 1'b0} + 16'd2;
        sx  = {{6{off[9]}}, off};
        return tk ? seq + (sx << 1) : seq;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at negedge, sample at following negedge (one posedge in between)
    task automatic run(logic [15:0] a, logic [2:0] cc, logic [9:0] off,
                       bit c, bit z, bit n, bit v, string req);
        bit tk;
        logic [15:0] ep;
        in_valid = 1'b1; instr_addr = a; cond = cc; offset = off;
        flag_c = c; flag_z = z; flag_n = n; flag_v = v;
        tk = want_take(cc, c, z, n, v);
        ep = want_pc(a, off, tk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R2 out_valid", 32'(out_valid), 32'd1);
        chk(taken == tk, {req, " taken"}, 32'(taken), 32'(tk));
        chk(next_pc == ep, {req, " next_pc"}, 32'(next_pc), 32'(ep));
        chk(next_pc[0] == 1'b0, "R9 even pc", 32'(next_pc[0]), 32'd0);
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        logic [15:0] hold_pc;
        bit hold_tk;
        rst = 1'b1; in_valid = 1'b0; instr_addr = '0; cond = '0; offset = '0;
        flag_c = 0; flag_z = 0; flag_n = 0; flag_v = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 0 && taken == 0 && next_pc == 0, "R1 reset",
            {15'd0, out_valid, taken, next_pc}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 0 && taken == 0 && next_pc == 0, "R1 after reset",
            {15'd0, out_valid, taken, next_pc}, 32'd0);

        // R7 worked example
        run(16'hC028, 3'b111, 10'b1111110011, 0, 0, 0, 0, "R7 example");
        chk(next_pc == 16'hC010, "R7 literal", 32'(next_pc), 32'h0000C010);
        // R3 zero conditions
        run(16'h1000, 3'b000, 10'd4, 1, 0, 1, 1, "R3 z0 taken");
        run(16'h1000, 3'b000, 10'd4, 0, 1, 0, 0, "R3 z1 not");
        run(16'h1000, 3'b001, 10'd4, 0, 1, 0, 0, "R3 z1 taken");
        // R4 carry conditions
        run(16'h2000, 3'b010, 10'h3FF, 0, 1, 1, 1, "R4 c0 taken");
        run(16'h2000, 3'b011, 10'h3FF, 0, 0, 0, 0, "R4 c0 not");
        // R5 negative only
        run(16'h3000, 3'b100, 10'd8, 1, 1, 0, 1, "R5 n0 not");
        run(16'h3000, 3'b100, 10'd8, 0, 0, 1, 0, "R5 n1 taken");
        // R6 signed and always
        run(16'h4000, 3'b101, 10'd1, 0, 0, 1, 1, "R6 ge taken");
        run(16'h4000, 3'b110, 10'd1, 0, 0, 1, 1, "R6 lt not");
        run(16'h4000, 3'b110, 10'd1, 0, 0, 0, 1, "R6 lt taken");
        // R7 reach and wrap
        run(16'h5000, 3'b111, 10'h200, 0, 0, 0, 0, "R7 min reach");
        chk(next_pc == 16'h4C02, "R7 -1024", 32'(next_pc), 32'h4C02);
        run(16'h5000, 3'b111, 10'h1FF, 0, 0, 0, 0, "R7 max reach");
        chk(next_pc == 16'h5400, "R7 +1022", 32'(next_pc), 32'h5400);
        run(16'hFFF0, 3'b111, 10'd20, 0, 0, 0, 0, "R7 wrap up");
        run(16'h0002, 3'b111, 10'h200, 0, 0, 0, 0, "R7 wrap down");
        // R8 sequential wrap, R9 odd address
        run(16'hFFFE, 3'b000, 10'd5, 0, 1, 0, 0, "R8 seq wrap");
        chk(next_pc == 16'h0000, "R8 0xFFFE", 32'(next_pc), 32'h0);
        run(16'h6001, 3'b111, 10'd3, 0, 0, 0, 0, "R9 odd addr");
        chk(next_pc == 16'h6008, "R9 odd literal", 32'(next_pc), 32'h6008);

        // R10 hold while idle, with inputs wiggled
        hold_pc = next_pc; hold_tk = taken;
        instr_addr = 16'h1234; cond = 3'b111; offset = 10'h155;
        repeat (3) @(negedge clk);
        chk(out_valid == 0, "R2 idle", 32'(out_valid), 32'd0);
        chk(next_pc == hold_pc && taken == hold_tk, "R10 hold",
            {15'd0, taken, next_pc}, {15'd0, hold_tk, hold_pc});

        // Exhaustive condition/flag pairs (R3..R6) with random addresses
        for (int k = 0; k < 128; k++) begin
            run(16'($urandom), k[6:4], 10'($urandom), k[0], k[1], k[2], k[3],
                "R3-6 sweep");
        end
        // Constrained random
        seed = 32'h5EED;
        void'($urandom(seed));
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            run(16'($urandom), r[2:0], r[12:3], r[13], r[14], r[15], r[16],
                "R7 random");
            if (r[20]) @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule